// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block is the hardware loop controller that sits beside the fetch stage of a small instruction sequencer. Software arms a loop with one setup command placed before the loop body. The command carries the first and last body addresses, an iteration count and an optional termination condition. After that, no instruction inside the body is needed to make it repeat.

On every cycle the controller compares the current fetch address with the last body address of the innermost armed loop. In the same cycle it produces the next fetch address. That address is the loop start when the loop repeats, the address just past the body when the loop ends, and the sequential successor otherwise. Because of this there is no branch instruction and no bubble between iterations. A loop ends either when its down-counter reaches its final pass or, in condition mode, when a selected flag input is true at the last body address. Nested loops are held in a small context stack. A setup pushes a context and a loop exit pops it.

Top module: `loop_seq`

## Requirements
- R1: With no loop armed (`depth` = 0), `next_pc` equals `fetch_pc` + 1 modulo 2^AW, and both `loop_back` and `loop_exit` stay low.
- R2: A setup pulse with room on the stack pushes a context, and `depth` is one higher in the following cycle.
- R3: In count mode (`setup_cond` = 0), when `fetch_pc` equals the innermost end address and passes remain, `loop_back` is high and `next_pc` equals the start address in that same cycle. A body of L words with count N therefore takes exactly N·L fetch cycles.
- R4: On the final pass at the end address, `loop_exit` is high, `next_pc` is the end address + 1, and the context is popped so that `depth` drops by one in the next cycle.
- R5: A setup count of 0 behaves exactly like a count of 1, so the body runs once.
- R6: In condition mode (`setup_cond` = 1), the count is ignored. The loop exits at the end address in the cycle when `flags[setup_flag_sel]` is 1 and loops back otherwise. Flags at other positions have no effect.
- R7: Only the innermost context is compared with `fetch_pc`. When an inner loop exits, the enclosing loop resumes its own counting unchanged.
- R8: A setup while `depth` = DEPTH (4 by default) and no exit in the same cycle is discarded, leaving the stack unchanged. It also sets `overflow`, which stays high until reset.
- R9: After reset, `depth` = 0 and `overflow` = 0.
- R10: When a setup and a loop exit happen in the same cycle, the exiting context is popped and the new one takes its place, so `depth` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | AW | Address being fetched this cycle |
| setup_valid | input | 1 | Loop setup command this cycle |
| setup_start | input | AW | First body address |
| setup_end | input | AW | Last body address |
| setup_count | input | CW | Iteration count (0 treated as 1) |
| setup_cond | input | 1 | 1 = end on flag, 0 = end on count |
| setup_flag_sel | input | FSW | Index of the flag tested in condition mode |
| flags | input | NFLAG | Condition flags from the execution side |
| next_pc | output | AW | Address to fetch next cycle |
| loop_back | output | 1 | Redirect to loop start this cycle |
| loop_exit | output | 1 | Innermost loop finishes this cycle |
| loop_active | output | 1 | At least one loop armed |
| depth | output | DW | Number of armed contexts |
| overflow | output | 1 | Sticky: a setup was dropped on a full stack |

## Verification
A corrupted counter in a stacked context shows up at the ports the next time fetch reaches that loop's end address. The iteration count seen on `next_pc` comes out short or long, and the total fetch cycles stop matching N·L. A wrong stack pointer or a wrong write slot shows up within one pop. The exit address, or a flag-driven exit, then belongs to the wrong loop, or `depth` disagrees with the count of pushes and pops the bench has made. A dropped push that still gets stored can be seen later: after every real context has been popped, fetching the dropped loop's end address still redirects.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;
  typedef enum logic [1:0] {
    ACT_STEP = 2'd0,
    ACT_BACK = 2'd1,
    ACT_EXIT = 2'd2
  } loop_act_e;
endpackage

// File: rtl/loop_ctx_stack.sv
// Context stack for nested hardware loops: one entry per armed loop.
module loop_ctx_stack #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  parameter int FSW   = 2,
  parameter int DW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic           dec_i,
  input  logic [AW-1:0]  new_start_i,
  input  logic [AW-1:0]  new_end_i,
  input  logic [CW-1:0]  new_count_i,
  input  logic           new_cond_i,
  input  logic [FSW-1:0] new_sel_i,
  output logic [AW-1:0]  top_start_o,
  output logic [AW-1:0]  top_end_o,
  output logic [CW-1:0]  top_count_o,
  output logic           top_cond_o,
  output logic [FSW-1:0] top_sel_o,
  output logic [DW-1:0]  depth_o,
  output logic           ovf_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]  start_q [DEPTH];
  logic [AW-1:0]  end_q   [DEPTH];
  logic [CW-1:0]  count_q [DEPTH];
  logic           cond_q  [DEPTH];
  logic [FSW-1:0] sel_q   [DEPTH];

  logic [DW-1:0]  depth_q, depth_d, base;
  logic           ovf_q, ovf_d;
  logic           pop_eff, push_ok;
  logic [IW-1:0]  top_idx, wr_idx;
  logic [CW-1:0]  count_load;

  // next-state for pointer and sticky flag
  always_comb begin
    pop_eff    = pop_i && (depth_q != '0);
    base       = depth_q - DW'(pop_eff);
    push_ok    = push_i && (base < DW'(DEPTH));
    depth_d    = base + DW'(push_ok);
    ovf_d      = ovf_q | (push_i & ~push_ok);
    top_idx    = IW'(depth_q - DW'(1));
    wr_idx     = IW'(base);
    count_load = (new_count_i == '0) ? CW'(1) : new_count_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic          wr_en, dec_en;
    logic [CW-1:0] cnt_d;

    always_comb begin
      wr_en  = push_ok && (wr_idx == IW'(g));
      dec_en = dec_i && !pop_eff && (depth_q != '0) && (top_idx == IW'(g));
      cnt_d  = count_q[g];
      if (wr_en)       cnt_d = count_load;
      else if (dec_en) cnt_d = count_q[g] - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[g] <= '0;
        end_q[g]   <= '0;
        cond_q[g]  <= 1'b0;
        sel_q[g]   <= '0;
      end else if (wr_en) begin
        start_q[g] <= new_start_i;
        end_q[g]   <= new_end_i;
        cond_q[g]  <= new_cond_i;
        sel_q[g]   <= new_sel_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               count_q[g] <= '0;
      else if (wr_en || dec_en) count_q[g] <= cnt_d;
    end
  end

  assign top_start_o = start_q[top_idx];
  assign top_end_o   = end_q[top_idx];
  assign top_count_o = count_q[top_idx];
  assign top_cond_o  = cond_q[top_idx];
  assign top_sel_o   = sel_q[top_idx];
  assign depth_o     = depth_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/loop_term_eval.sv
// Same-cycle decision: keep stepping, jump back, or leave the loop.
module loop_term_eval
  import loop_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int NFLAG = 4,
  parameter int FSW   = 2
) (
  input  logic             active_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    end_i,
  input  logic [CW-1:0]    count_i,
  input  logic             cond_i,
  input  logic [FSW-1:0]   sel_i,
  input  logic [NFLAG-1:0] flags_i,
  output loop_act_e        act_o
);
  logic at_end, finished;

  always_comb begin
    at_end   = active_i && (pc_i == end_i);
    finished = cond_i ? flags_i[sel_i] : (count_i <= CW'(1));
    if (!at_end)      act_o = ACT_STEP;
    else if (finished) act_o = ACT_EXIT;
    else              act_o = ACT_BACK;
  end
endmodule

// File: rtl/loop_pc_mux.sv
module loop_pc_mux
  import loop_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  loop_act_e      act_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [AW-1:0]  start_i,
  input  logic [AW-1:0]  end_i,
  output logic [AW-1:0]  next_pc_o
);
  always_comb begin
    unique case (act_i)
      ACT_BACK: next_pc_o = start_i;
      ACT_EXIT: next_pc_o = end_i + AW'(1);
      default:  next_pc_o = pc_i + AW'(1);
    endcase
  end
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  parameter int NFLAG = 4,
  parameter int FSW   = (NFLAG > 1) ? $clog2(NFLAG) : 1,
  parameter int DW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    fetch_pc,
  input  logic             setup_valid,
  input  logic [AW-1:0]    setup_start,
  input  logic [AW-1:0]    setup_end,
  input  logic [CW-1:0]    setup_count,
  input  logic             setup_cond,
  input  logic [FSW-1:0]   setup_flag_sel,
  input  logic [NFLAG-1:0] flags,
  output logic [AW-1:0]    next_pc,
  output logic             loop_back,
  output logic             loop_exit,
  output logic             loop_active,
  output logic [DW-1:0]    depth,
  output logic             overflow
);
  logic [AW-1:0]  top_start, top_end;
  logic [CW-1:0]  top_count;
  logic           top_cond;
  logic [FSW-1:0] top_sel;
  loop_act_e      act;
  logic           dec;

  assign loop_active = (depth != '0);
  assign loop_back   = (act == ACT_BACK);
  assign loop_exit   = (act == ACT_EXIT);
  assign dec         = loop_back && !top_cond;

  loop_ctx_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .FSW(FSW), .DW(DW)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (setup_valid),
    .pop_i       (loop_exit),
    .dec_i       (dec),
    .new_start_i (setup_start),
    .new_end_i   (setup_end),
    .new_count_i (setup_count),
    .new_cond_i  (setup_cond),
    .new_sel_i   (setup_flag_sel),
    .top_start_o (top_start),
    .top_end_o   (top_end),
    .top_count_o (top_count),
    .top_cond_o  (top_cond),
    .top_sel_o   (top_sel),
    .depth_o     (depth),
    .ovf_o       (overflow)
  );

  loop_term_eval #(.AW(AW), .CW(CW), .NFLAG(NFLAG), .FSW(FSW)) u_eval (
    .active_i (loop_active),
    .pc_i     (fetch_pc),
    .end_i    (top_end),
    .count_i  (top_count),
    .cond_i   (top_cond),
    .sel_i    (top_sel),
    .flags_i  (flags),
    .act_o    (act)
  );

  loop_pc_mux #(.AW(AW)) u_mux (
    .act_i     (act),
    .pc_i      (fetch_pc),
    .start_i   (top_start),
    .end_i     (top_end),
    .next_pc_o (next_pc)
  );
endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int DW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fetch_pc,
  input logic          setup_valid,
  input logic [AW-1:0] next_pc,
  input logic          loop_back,
  input logic          loop_exit,
  input logic [DW-1:0] depth,
  input logic          overflow
);
  p_idle_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) |-> (next_pc == fetch_pc + AW'(1)) && !loop_back && !loop_exit);

  p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && !loop_exit && depth < DW'(DEPTH)) |=> (depth == $past(depth) + DW'(1)));

  p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(loop_back && loop_exit));

  p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_exit && !setup_valid) |=> (depth == $past(depth) - DW'(1)));

  p_sticky_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && !loop_exit && depth == DW'(DEPTH)) |=> (depth == DW'(DEPTH)) && overflow);

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(setup_valid && !loop_exit && depth == DW'(DEPTH)));

  p_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && loop_exit) |=> (depth == $past(depth)));
endmodule

bind loop_seq loop_seq_chk #(.AW(AW), .DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/tb_loop_seq.sv
`timescale 1ns/1ps
module tb_loop_seq;
  localparam int AW = 16, CW = 16, DEPTH = 4, NFLAG = 4, FSW = 2, DW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0]    fetch_pc;
  logic             setup_valid;
  logic [AW-1:0]    setup_start, setup_end;
  logic [CW-1:0]    setup_count;
  logic             setup_cond;
  logic [FSW-1:0]   setup_flag_sel;
  logic [NFLAG-1:0] flags;
  logic [AW-1:0]    next_pc;
  logic             loop_back, loop_exit, loop_active, overflow;
  logic [DW-1:0]    depth;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  loop_seq dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    setup_valid = 0; setup_start = '0; setup_end = '0; setup_count = '0;
    setup_cond = 0; setup_flag_sel = '0; flags = '0; fetch_pc = 16'd5;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic setup_now(input logic [AW-1:0] st, input logic [AW-1:0] en,
                           input int cnt, input bit cnd, input int sel);
    setup_valid = 1; setup_start = st; setup_end = en;
    setup_count = CW'(cnt); setup_cond = cnd; setup_flag_sel = FSW'(sel);
  endtask

  // arm one loop, then follow next_pc until it exits
  task automatic run_loop(input logic [AW-1:0] st, input int len, input int cnt,
                          input bit cnd, input int sel, input int k,
                          output int visits, output int exit_pc, output int cycles);
    logic [AW-1:0] en, np;
    en = st + AW'(len - 1);
    visits = 0; exit_pc = -1; cycles = 0;
    fetch_pc = st - AW'(1);
    setup_now(st, en, cnt, cnd, sel);
    @(posedge clk); #1;
    setup_valid = 0;
    fetch_pc = st;
    for (int c = 0; c < 2000; c++) begin
      if (cnd) flags = (fetch_pc == en && visits + 1 >= k) ? NFLAG'(1 << sel) : ~NFLAG'(1 << sel);
      @(negedge clk);
      cycles++;
      if (fetch_pc == en) visits++;
      np = next_pc;
      if (loop_exit) begin
        exit_pc = int'(next_pc);
        @(posedge clk); #1;
        fetch_pc = np; flags = '0;
        break;
      end
      @(posedge clk); #1;
      fetch_pc = np;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    int v, ep, cy, exp_v;
    logic [AW-1:0] np;
    do_reset();

    // R9 reset state and R1 sequential stepping
    @(negedge clk);
    chk(depth == 0, "R9 depth after reset", depth, 0);
    chk(overflow == 0, "R9 overflow after reset", overflow, 0);
    for (int p = 0; p < 4; p++) begin
      fetch_pc = (p == 3) ? 16'hFFFF : AW'(p * 1000 + 7);
      #1;
      chk(next_pc == fetch_pc + AW'(1) && !loop_back && !loop_exit, "R1 idle step",
          next_pc, int'(fetch_pc + AW'(1)));
    end

    // R2 push visible next cycle
    @(posedge clk); #1;
    setup_now(16'd40, 16'd42, 2, 0, 0); fetch_pc = 16'd39;
    @(posedge clk); #1; setup_valid = 0;
    @(negedge clk);
    chk(depth == 1 && loop_active, "R2 depth after setup", depth, 1);
    fetch_pc = 16'd42; #1;
    chk(loop_back && next_pc == 16'd40, "R3 redirect to start", next_pc, 40);
    @(posedge clk); #1; fetch_pc = 16'd42;
    @(negedge clk);
    chk(loop_exit && next_pc == 16'd43, "R4 exit address", next_pc, 43);
    @(posedge clk); #1; fetch_pc = 16'd43;
    @(negedge clk);
    chk(depth == 0, "R4 pop on exit", depth, 0);

    // R3 R4 R5 count-mode sweep
    for (int cnt = 0; cnt <= 5; cnt++) begin
      for (int len = 1; len <= 3; len++) begin
        run_loop(AW'(200 + 16 * len), len, cnt, 0, 0, 0, v, ep, cy);
        exp_v = (cnt == 0) ? 1 : cnt;
        chk(v == exp_v, (cnt == 0) ? "R5 zero count runs once" : "R3 iteration count", v, exp_v);
        chk(cy == exp_v * len, "R3 no bubble cycles", cy, exp_v * len);
        chk(ep == 200 + 16 * len + len, "R4 exit pc", ep, 200 + 16 * len + len);
        @(negedge clk);
        chk(depth == 0, "R4 depth after exit", depth, 0);
      end
    end

    // R6 condition-mode sweep: count says 1, flag decides
    for (int sel = 0; sel < NFLAG; sel++) begin
      for (int k = 1; k <= 4; k++) begin
        run_loop(16'd300, 2, 1, 1, sel, k, v, ep, cy);
        chk(v == k, "R6 flag terminated loop", v, k);
        chk(ep == 302, "R6 exit pc", ep, 302);
      end
    end

    // R7 nested: outer 100..109 x3, inner 103..105 x2 armed at pc 102
    begin
      int inner_v = 0, outer_v = 0, inner_x = 0, max_d = 0;
      fetch_pc = 16'd99; setup_now(16'd100, 16'd109, 3, 0, 0);
      @(posedge clk); #1; setup_valid = 0; fetch_pc = 16'd100;
      for (int c = 0; c < 300; c++) begin
        if (fetch_pc == 16'd102) setup_now(16'd103, 16'd105, 2, 0, 0);
        else setup_valid = 0;
        @(negedge clk);
        if (int'(depth) > max_d) max_d = int'(depth);
        if (fetch_pc == 16'd105) inner_v++;
        if (fetch_pc == 16'd109) outer_v++;
        if (loop_exit && fetch_pc == 16'd105) inner_x++;
        np = next_pc;
        if (loop_exit && fetch_pc == 16'd109) begin
          chk(next_pc == 16'd110, "R7 outer exit pc", next_pc, 110);
          @(posedge clk); #1; setup_valid = 0; fetch_pc = np;
          break;
        end
        @(posedge clk); #1; fetch_pc = np;
      end
      chk(inner_v == 6, "R7 inner end visits", inner_v, 6);
      chk(inner_x == 3, "R7 inner exits", inner_x, 3);
      chk(outer_v == 3, "R7 outer end visits", outer_v, 3);
      chk(max_d == 2, "R7 nesting depth", max_d, 2);
      @(negedge clk);
      chk(depth == 0, "R7 depth after nest", depth, 0);
    end

    // R8 overflow
    fetch_pc = 16'd500;
    for (int i = 0; i < 4; i++) begin
      setup_now(16'd590, AW'(600 + i), 1, 0, 0);
      @(posedge clk); #1;
    end
    setup_valid = 0;
    @(negedge clk);
    chk(depth == 4 && !overflow, "R8 full without overflow", depth, 4);
    @(posedge clk); #1;
    setup_now(16'd690, 16'd700, 3, 0, 0);
    @(posedge clk); #1; setup_valid = 0;
    @(negedge clk);
    chk(depth == 4, "R8 depth unchanged", depth, 4);
    chk(overflow == 1, "R8 overflow set", overflow, 1);
    for (int i = 3; i >= 0; i--) begin
      @(posedge clk); #1; fetch_pc = AW'(600 + i);
      @(negedge clk);
      chk(loop_exit && next_pc == AW'(601 + i), "R8 stored contexts intact", next_pc, 601 + i);
    end
    @(posedge clk); #1; fetch_pc = 16'd700;
    @(negedge clk);
    chk(depth == 0 && !loop_back && next_pc == 16'd701, "R8 dropped setup not stored", next_pc, 701);
    chk(overflow == 1, "R8 overflow sticky", overflow, 1);

    // R10 setup and exit in the same cycle
    @(posedge clk); #1;
    fetch_pc = 16'd799; setup_now(16'd800, 16'd800, 1, 0, 0);
    @(posedge clk); #1;
    fetch_pc = 16'd800; setup_now(16'd900, 16'd905, 1, 0, 0);
    @(negedge clk);
    chk(loop_exit, "R10 exit while setup", loop_exit, 1);
    @(posedge clk); #1; setup_valid = 0;
    @(negedge clk);
    chk(depth == 1, "R10 depth unchanged", depth, 1);
    chk(!loop_exit && next_pc == 16'd801, "R10 old context gone", next_pc, 801);
    fetch_pc = 16'd905; #1;
    chk(loop_exit && next_pc == 16'd906, "R10 new context on top", next_pc, 906);

    // R9 reset clears overflow
    do_reset();
    @(negedge clk);
    chk(overflow == 0 && depth == 0, "R9 reset clears state", overflow, 0);

    done_flag = 1;
    report();
  end
endmodule